// File: doc/BRIEF.md
# Frame Delay Compare Timer

This block times the gap between the end of a reader's modulation pause and the start of the card's synchronous reply. A 16-bit counter advances once for every carrier clock enable. A falling edge on the demodulated-data input zeroes it and starts it again. Three programmable compare values act on the running count:

- **A:** when the count reaches A, the waveform output goes high. That rising edge is the request to start a transmit frame.
- **B:** a match on B only records that the frame has ended.
- **C:** a match on C drives the waveform output low and halts the counter, which waits for the next trigger.

A small register write port loads the three compare values and the interrupt enable mask. Four sticky event flags record the trigger, A match, B match and C match. Reading the status clears the flags. A level interrupt is raised while any enabled flag is set. No data stream flows through the block, so every port is a plain control or status pin and there is no valid/ready back-pressure. A one-cycle software start pulse launches the counter from zero after reset.

Top module: `fdt_compare_timer`

## Requirements
- R1: After reset the counter reads 0 and is halted, the waveform output is 0, all flags are 0 and irq is 0. Carrier ticks do not move a halted counter.
- R2: While running, each cycle with `carrier_tick` high adds one to the count, wrapping from 0xFFFF to 0. Without a tick the count holds.
- R3: A falling edge of `trig_in` passes through two synchronising flops. If the low level is first sampled at clock edge k, then after edge k+2: the count is 0, the counter runs, `wave_out` is 0 and flag bit 0 (trigger) is set. A rising edge of `trig_in` has no effect.
- R4: A compare match is a cycle in which all of the following hold: the counter runs, `carrier_tick` is high, no trigger is acted on, no start pulse is present, and the count equals the compare value. An A match sets `wave_out` high and sets flag bit 1.
- R5: A B match sets flag bit 2 and changes neither `wave_out` nor the count sequence.
- R6: A C match sets flag bit 3, drives `wave_out` low and halts the counter at the matched value. The counter stays there until a trigger or a start pulse. If A and C match in the same cycle, `wave_out` ends low.
- R7: A trigger acted on in the same cycle as a compare match wins: no compare flag is set, the count becomes 0 and `wave_out` becomes 0.
- R8: The reset values of the compare registers are A = 0x0000, B = 256 (0x0100) and C = 0xFFFF.
- R9: A write with `cfg_wr` high loads `cfg_wdata` into the register chosen by `cfg_sel`: 0 = A, 1 = B, 2 = C, 3 = interrupt enable (bits 3:0). The new value is used from the next cycle on.
- R10: The flags are sticky. A cycle with `stat_rd` high clears them, but an event in that same cycle stays set.
- R11: `irq` is high exactly when some flag bit is set and its enable bit is also set. The enable bits are in flag order: bit 0 trigger, 1 A, 2 B, 3 C.
- R12: A `sw_start` pulse zeroes the count and makes the counter run. It changes neither `wave_out` nor the flags, and a trigger in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_tick | input | 1 | One-cycle enable per carrier clock period |
| trig_in | input | 1 | Demodulated data; a falling edge restarts the count |
| sw_start | input | 1 | Software start pulse |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 A, 1 B, 2 C, 3 interrupt enable |
| cfg_wdata | input | 16 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| stat_flags | output | 4 | Sticky flags: bit 0 trigger, 1 A, 2 B, 3 C |
| cnt_val | output | 16 | Current count |
| wave_out | output | 1 | Waveform output; a rising edge starts a transmit frame |
| irq | output | 1 | Level interrupt |

## Verification
Directed runs use several patterns:

- **Default-compare start:** shows the reset values of A and B by the exact tick on which each fires.
- **Short C value:** separates a halt from a wrap.
- **Trigger with a slow rise and a late fall:** tells the two-flop latency apart from an unsynchronised path, and a rising-edge response apart from a falling-edge one.
- **Fall timed onto the A-match tick:** tells trigger priority apart from compare priority.
- **Write just before a match:** shows that a new compare value applies on the very next cycle.

A long run of seeded random ticks, trigger toggles, start pulses, register writes and status reads follows. Each cycle it compares count, waveform, flags and interrupt against a bench model, which exposes ordering mistakes between events that coincide.

// File: rtl/fdt_pkg.sv
package fdt_pkg;
  localparam int NCMP   = 3;
  localparam int NFLAG  = 4;
  localparam int SEL_W  = 2;

  // compare slot indices
  localparam int IDX_A = 0;
  localparam int IDX_B = 1;
  localparam int IDX_C = 2;

  // flag bit positions
  localparam int FLG_TRIG = 0;
  localparam int FLG_A    = 1;
  localparam int FLG_B    = 2;
  localparam int FLG_C    = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMP_A  = 2'd0,
    SEL_CMP_B  = 2'd1,
    SEL_CMP_C  = 2'd2,
    SEL_IRQ_EN = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/fdt_trig_sync.sv
module fdt_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  localparam int LAST = STAGES;

  logic [LAST:0] sh_q;

  genvar g;
  generate
    for (g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sh_q[g] <= 1'b0;
          else        sh_q[g] <= sh_q[g-1];
        end
      end
    end
  endgenerate

  // synchronised value is sh_q[LAST-1]; sh_q[LAST] is its previous value
  assign fall = sh_q[LAST] & ~sh_q[LAST-1];

  // R3: a detected fall means the synchronised level was high and is now low
  p_fall_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !sh_q[LAST]);
endmodule

// File: rtl/fdt_cfg_regs.sv
module fdt_cfg_regs
  import fdt_pkg::*;
#(
  parameter int          W     = 16,
  parameter logic [W-1:0] A_RST = '0,
  parameter logic [W-1:0] B_RST = W'(256),
  parameter logic [W-1:0] C_RST = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [W-1:0]              wr_data,
  output logic [NCMP-1:0][W-1:0]    cmp_vals,
  output logic [NFLAG-1:0]          irq_en
);
  genvar i;
  generate
    for (i = 0; i < NCMP; i++) begin : g_cmp
      localparam logic [W-1:0] RV = (i == IDX_A) ? A_RST :
                                    (i == IDX_B) ? B_RST : C_RST;
      localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
      logic [W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         val_q <= RV;
        else if (wr_en && wr_sel == MY_SEL) val_q <= wr_data;
      end
      assign cmp_vals[i] = val_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  irq_en <= '0;
    else if (wr_en && wr_sel == SEL_IRQ_EN)      irq_en <= wr_data[NFLAG-1:0];
  end

  // R9: a register not addressed by a write keeps its value
  p_no_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_IRQ_EN) |=> $stable(irq_en));
endmodule

// File: rtl/fdt_cnt_core.sv
module fdt_cnt_core
  import fdt_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   trig,
  input  logic                   start,
  input  logic [NCMP-1:0][W-1:0] cmp_vals,
  output logic [W-1:0]           cnt,
  output logic                   running,
  output logic                   wave,
  output logic [NCMP-1:0]        hit_evt
);
  logic [W-1:0]    cnt_q;
  logic            run_q;
  logic            wave_q;
  logic            cmp_ok;
  logic [NCMP-1:0] hit_raw;

  genvar i;
  generate
    for (i = 0; i < NCMP; i++) begin : g_cmp
      assign hit_raw[i] = (cnt_q == cmp_vals[i]);
    end
  endgenerate

  assign cmp_ok  = run_q & tick & ~trig & ~start;
  assign hit_evt = hit_raw & {NCMP{cmp_ok}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      wave_q <= 1'b0;
    end else if (trig) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
      wave_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= '0;
      run_q  <= 1'b1;
    end else if (cmp_ok) begin
      if (hit_evt[IDX_C]) begin
        run_q  <= 1'b0;
        wave_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (hit_evt[IDX_A]) wave_q <= 1'b1;
      end
    end
  end

  assign cnt     = cnt_q;
  assign running = run_q;
  assign wave    = wave_q;

  // R2: plain step while running
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && !trig && !start && !hit_raw[IDX_C]) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R3: trigger restarts from zero with the waveform low
  p_trig_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == '0 && run_q && !wave_q));

  // R4: A match without C raises the waveform
  p_wave_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_evt[IDX_A] && !hit_evt[IDX_C]) |=> wave_q);

  // R6: C match halts and lowers the waveform; a halted counter holds
  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt[IDX_C] |=> (!run_q && !wave_q && $stable(cnt_q)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !trig && !start) |=> (!run_q && $stable(cnt_q)));

  // R12: start pulse zeroes and runs
  p_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !trig) |=> (cnt_q == '0 && run_q && $stable(wave_q)));
endmodule

// File: rtl/fdt_status.sv
module fdt_status
  import fdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] evt,
  input  logic             rd,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] flags,
  output logic             irq
);
  logic [NFLAG-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd ? '0 : flags_q) | evt;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & irq_en);

  // R10: sticky without a read
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R10: read with no event leaves all flags clear
  p_read_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evt == '0) |=> (flags_q == '0));

  // R11: no flags, no interrupt
  p_irq_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> !irq);
endmodule

// File: rtl/fdt_compare_timer.sv
module fdt_compare_timer
  import fdt_pkg::*;
#(
  parameter int           CNT_W       = 16,
  parameter int           SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] CMP_A_RST = '0,
  parameter logic [CNT_W-1:0] CMP_B_RST = CNT_W'(256),
  parameter logic [CNT_W-1:0] CMP_C_RST = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 carrier_tick,
  input  logic                 trig_in,
  input  logic                 sw_start,
  input  logic                 cfg_wr,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CNT_W-1:0]     cfg_wdata,
  input  logic                 stat_rd,
  output logic [NFLAG-1:0]     stat_flags,
  output logic [CNT_W-1:0]     cnt_val,
  output logic                 wave_out,
  output logic                 irq
);
  logic                       trig_fall;
  logic [NCMP-1:0][CNT_W-1:0] cmp_vals;
  logic [NFLAG-1:0]           irq_en;
  logic [NCMP-1:0]            hit_evt;
  logic [NFLAG-1:0]           events;
  logic                       running;

  fdt_trig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (trig_in),
    .fall (trig_fall)
  );

  fdt_cfg_regs #(
    .W    (CNT_W),
    .A_RST(CMP_A_RST),
    .B_RST(CMP_B_RST),
    .C_RST(CMP_C_RST)
  ) i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .cmp_vals(cmp_vals),
    .irq_en  (irq_en)
  );

  fdt_cnt_core #(.W(CNT_W)) i_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (carrier_tick),
    .trig    (trig_fall),
    .start   (sw_start),
    .cmp_vals(cmp_vals),
    .cnt     (cnt_val),
    .running (running),
    .wave    (wave_out),
    .hit_evt (hit_evt)
  );

  always_comb begin
    events           = '0;
    events[FLG_TRIG] = trig_fall;
    events[FLG_A]    = hit_evt[IDX_A];
    events[FLG_B]    = hit_evt[IDX_B];
    events[FLG_C]    = hit_evt[IDX_C];
  end

  fdt_status i_stat (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (events),
    .rd    (stat_rd),
    .irq_en(irq_en),
    .flags (stat_flags),
    .irq   (irq)
  );

  // R7: a trigger acted on leaves no compare flag raised in that cycle
  p_trig_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_fall && stat_rd) |=> (stat_flags == 4'b0001));

  // R1: an idle halted counter does not move on carrier ticks
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !trig_fall && !sw_start && carrier_tick) |=> $stable(cnt_val));
endmodule

// File: tb/test_fdt_compare_timer.sv
module test_fdt_compare_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        carrier_tick = 1'b0;
  logic        trig_in = 1'b0;
  logic        sw_start = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        stat_rd = 1'b0;
  logic [3:0]  stat_flags;
  logic [15:0] cnt_val;
  logic        wave_out;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit trig_lvl = 1'b0;

  // bench model state
  bit        ms1, ms2, ms3;
  bit [15:0] mcnt;
  bit        mrun, mwave;
  bit [3:0]  mflags, mien;
  bit [15:0] mA, mB, mC;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdt_compare_timer i_fdt_compare_timer (
    .clk(clk), .rst_n(rst_n), .carrier_tick(carrier_tick), .trig_in(trig_in),
    .sw_start(sw_start), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stat_rd(stat_rd), .stat_flags(stat_flags), .cnt_val(cnt_val),
    .wave_out(wave_out), .irq(irq)
  );

  function automatic bit model_irq();
    return |(mflags & mien);
  endfunction

  task automatic model_reset();
    ms1 = 0; ms2 = 0; ms3 = 0;
    mcnt = 0; mrun = 0; mwave = 0; mflags = 0; mien = 0;
    mA = 16'h0000; mB = 16'd256; mC = 16'hFFFF;   // R8
  endtask

  task automatic model_step(bit tg, bit tk, bit st, bit wr, bit [1:0] sel,
                            bit [15:0] d, bit rd);
    bit fall, ok, hA, hB, hC;
    fall = ms3 & ~ms2;
    ok   = mrun & tk & ~fall & ~st;
    hA = ok && (mcnt == mA);
    hB = ok && (mcnt == mB);
    hC = ok && (mcnt == mC);
    mflags = (rd ? 4'b0 : mflags) | {hC, hB, hA, fall};
    if (fall) begin
      mcnt = 0; mrun = 1; mwave = 0;
    end else if (st) begin
      mcnt = 0; mrun = 1;
    end else if (ok) begin
      if (hC) begin mrun = 0; mwave = 0; end
      else begin mcnt = mcnt + 16'd1; if (hA) mwave = 1; end
    end
    if (wr) begin
      case (sel)
        2'd0: mA = d;
        2'd1: mB = d;
        2'd2: mC = d;
        default: mien = d[3:0];
      endcase
    end
    ms3 = ms2; ms2 = ms1; ms1 = tg;
  endtask

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample a quarter period after the posedge
  task automatic cyc(bit tk, bit st, bit wr, bit [1:0] sel, bit [15:0] d, bit rd);
    @(negedge clk);
    trig_in = trig_lvl; carrier_tick = tk; sw_start = st;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = d; stat_rd = rd;
    model_step(trig_lvl, tk, st, wr, sel, d, rd);
    @(posedge clk);
    #(CLK_PERIOD/4);
    tests++;
    if (cnt_val != mcnt || wave_out != mwave || stat_flags != mflags || irq != model_irq()) begin
      fails++;
      $display("FAIL R2/R4/R10/R11 model: actual cnt=%0d wave=%0b flags=%0h irq=%0b expected cnt=%0d wave=%0b flags=%0h irq=%0b",
               cnt_val, wave_out, stat_flags, irq, mcnt, mwave, mflags, model_irq());
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
  endtask
  task automatic wr_reg(bit [1:0] sel, bit [15:0] d);
    cyc(0, 0, 1, sel, d, 0);
  endtask
  task automatic rd_stat();
    cyc(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 cnt", cnt_val, 0);
    check("R1 wave", wave_out, 0);
    check("R1 flags", stat_flags, 0);
    check("R1 irq", irq, 0);
    ticks(5);
    check("R1 halted", cnt_val, 0);

    wr_reg(2'd3, 16'h000F);
    // R12 start; R8 default A = 0 fires on first tick
    cyc(0, 1, 0, 0, 0, 0);
    check("R12 start cnt", cnt_val, 0);
    ticks(1);
    check("R8 A default wave", wave_out, 1);
    check("R4 A flag", stat_flags[1], 1);
    ticks(255);
    check("R8 B not yet", stat_flags[2], 0);
    ticks(1);
    check("R8 B default", stat_flags[2], 1);
    check("R5 wave kept", wave_out, 1);
    check("R5 cnt", cnt_val, 257);
    check("R11 irq", irq, 1);

    // R6 stop at C
    wr_reg(2'd2, 16'd300);
    ticks(44);
    check("R6 cnt", cnt_val, 300);
    check("R6 wave low", wave_out, 0);
    check("R6 flags", stat_flags, 4'hE);
    ticks(10);
    check("R6 held", cnt_val, 300);

    // R10 read clears
    rd_stat();
    check("R10 cleared", stat_flags, 0);
    check("R11 irq off", irq, 0);

    wr_reg(2'd0, 16'd20);
    wr_reg(2'd2, 16'd40);
    // R3 rising edge has no effect, then two-flop latency
    trig_lvl = 1; ticks(4);
    check("R3 rise ignored", cnt_val, 300);
    trig_lvl = 0; ticks(2);
    check("R3 latency", cnt_val, 300);
    idle(1);
    check("R3 restart cnt", cnt_val, 0);
    check("R3 trig flag", stat_flags, 4'h1);
    ticks(20);
    check("R4 before A", wave_out, 0);
    ticks(1);
    check("R4 at A", wave_out, 1);
    check("R4 flags", stat_flags, 4'h3);

    // R3 trigger drives wave low
    trig_lvl = 1; idle(3);
    trig_lvl = 0; idle(3);
    check("R3 wave cleared", wave_out, 0);
    check("R3 cnt", cnt_val, 0);

    // R7 fall acted on the A-match tick
    rd_stat();
    trig_lvl = 1; idle(3);
    ticks(18);
    trig_lvl = 0; ticks(3);
    check("R7 cnt", cnt_val, 0);
    check("R7 wave", wave_out, 0);
    check("R7 flags", stat_flags, 4'h1);

    // R9 new B used on next cycle
    rd_stat();
    cyc(1, 0, 1, 2'd1, 16'd1, 0);
    ticks(1);
    check("R9 B write", stat_flags, 4'h4);

    // R11 enable masking
    wr_reg(2'd3, 16'h0008);
    check("R11 masked", irq, 0);
    wr_reg(2'd3, 16'h0004);
    check("R11 enabled", irq, 1);

    // R12 start while running
    cyc(1, 1, 0, 0, 0, 0);
    check("R12 restart", cnt_val, 0);

    // R2 wrap at 0xFFFF
    wr_reg(2'd2, 16'd5);
    wr_reg(2'd0, 16'd7);
    wr_reg(2'd1, 16'd7);
    wr_reg(2'd2, 16'hFFF0);
    cyc(0, 1, 0, 0, 0, 0);
    wr_reg(2'd2, 16'd3);
    ticks(70000 % 65536 + 2);
    check("R2 wrap halt", cnt_val, 3);

    // random phase
    wr_reg(2'd2, 16'd40);
    for (int n = 0; n < 6000; n++) begin
      bit tk, st, wr, rd;
      bit [1:0] sel;
      bit [15:0] d;
      if ($urandom % 100 < 4) trig_lvl = ~trig_lvl;
      tk  = ($urandom % 100) < 75;
      st  = ($urandom % 100) < 1;
      wr  = ($urandom % 100) < 4;
      rd  = ($urandom % 100) < 6;
      sel = 2'($urandom % 4);
      d   = (sel == 2'd3) ? 16'($urandom % 16) : 16'($urandom % 48);
      cyc(tk, st, wr, sel, d, rd);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule